// File: doc/BRIEF.md
# Bus-Attached Character Output Controller

This block connects a simple processor bus to a byte-at-a-time output device such as a printer. It claims one device slot by decoding the upper address bits. Within that slot it presents three addressable registers: a status word, a one-byte data register and a control word. Software writes a character to the data register. The block then passes that byte to the device with a single-cycle strobe and waits for the device to return a single-cycle completion pulse.

The same unit serves both a busy-wait driver and an interrupt-driven one. In polling mode (interrupt enable clear), software keeps reading the status word until the busy flag drops, and the block never raises its request line. In interrupt mode, every completed character raises a request that stays up until software acknowledges it. Software acknowledges by reading the status word or by writing the next character. The device's out-of-paper input appears in the status word. While that input is asserted, the block holds off any pending character.

Top module: `pxu_top`

## Requirements
- R1: The unit responds only when the top 3 address bits equal the slot parameter (default 5) and every address bit between that field and the 2-bit register offset is zero. Writes to any other address change nothing, and reads of any other address return 0.
- R2: Offset 0 is status, offset 1 is data, offset 2 is control, and offset 3 reads as 0. Control bit 0 is interrupt enable and reads back as written. A read of offset 1 returns the last accepted byte.
- R3: The status word has bit 0 busy, bit 1 paper-out, bit 2 interrupt pending and bit 3 overrun. All other bits read as 0.
- R4: When a data write is accepted, busy is set from the next clock edge. During the following cycle, per_strobe_o is high for exactly one cycle and per_data_o carries the written byte.
- R5: A per_done_i pulse after the strobe clears busy at the next edge. A per_done_i pulse while no character is outstanding has no effect.
- R6: A data write while status busy is set is ignored and sets the overrun bit. Overrun stays set until a read of the status word, which returns it and then clears it.
- R7: While per_paper_out_i is high, status shows busy and paper-out. An accepted character is then held without a strobe until the input falls, and the strobe follows after that.
- R8: The pending bit is set when a character completes. A status read or any data write clears it, and a new completion in the same cycle takes priority over the clear.
- R9: irq_o equals pending AND interrupt enable, so polling mode (enable 0) never raises irq_o.
- R10: After reset, every register is 0 and irq_o and per_strobe_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 16 | Bus address: slot select, reserved bits, register offset |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_rd_i | input | 1 | Read enable |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the read cycle, 0 otherwise |
| irq_o | output | 1 | Interrupt request |
| per_data_o | output | 8 | Byte presented to the device |
| per_strobe_o | output | 1 | One-cycle start pulse to the device |
| per_done_i | input | 1 | One-cycle completion pulse from the device |
| per_paper_out_i | input | 1 | Device is out of paper |

## Verification
The bench writes characters while the unit is busy. A design that accepted them would emit extra bytes, and the scoreboard would see those, or it would fail to flag overrun. The bench raises paper-out in the cycle just after a character is accepted. A design that ignored the input there would strobe too early. The bench also pulses completion while the unit is idle, where a wrong design would set pending. It checks that a status read and a data write each retire pending, and that polling mode keeps irq_o low. It aims accesses at a foreign slot to catch incomplete address decode.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} sq_state_e;

  localparam int OFF_STATUS = 0;
  localparam int OFF_DATA   = 1;
  localparam int OFF_CTRL   = 2;

  localparam int ST_BUSY    = 0;
  localparam int ST_PAPER   = 1;
  localparam int ST_PEND    = 2;
  localparam int ST_OVR     = 3;

  localparam int CTRL_IE    = 0;
endpackage

// File: rtl/pxu_decode.sv
module pxu_decode #(
  parameter int ADDR_W  = 16,
  parameter int SEL_W   = 3,
  parameter int REG_W   = 2,
  parameter int SLOT_ID = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [REG_W-1:0]  off_o
);
  localparam int MID_W = ADDR_W - SEL_W - REG_W;

  logic slot_ok, mid_ok;

  assign slot_ok = addr_i[ADDR_W-1 -: SEL_W] == SEL_W'(SLOT_ID);

  generate
    if (MID_W > 0) begin : g_mid
      assign mid_ok = addr_i[ADDR_W-SEL_W-1:REG_W] == '0;
    end else begin : g_nomid
      assign mid_ok = 1'b1;
    end
  endgenerate

  assign hit_o = slot_ok && mid_ok;
  assign off_o = addr_i[REG_W-1:0];
endmodule

// File: rtl/pxu_seq.sv
module pxu_seq
  import pxu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic paper_out_i,
  input  logic done_i,
  output logic strobe_o,
  output logic busy_o,
  output logic done_evt_o
);
  sq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:  if (start_i) state_d = SQ_ISSUE;
      SQ_ISSUE: if (!paper_out_i) state_d = SQ_WAIT;
      SQ_WAIT:  if (done_i) state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SQ_IDLE;
    else         state_q <= state_d;
  end

  // strobe held back while the device reports no paper
  assign strobe_o   = (state_q == SQ_ISSUE) && !paper_out_i;
  assign busy_o     = state_q != SQ_IDLE;
  assign done_evt_o = (state_q == SQ_WAIT) && done_i;

  // R4
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
  // R4
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  // R7
  paper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paper_out_i && state_q == SQ_ISSUE) |=> (state_q == SQ_ISSUE));
  // R5
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_evt_o |=> !busy_o);
endmodule

// File: rtl/pxu_regs.sv
module pxu_regs
  import pxu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [REG_W-1:0]  off_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              seq_busy_i,
  input  logic              paper_out_i,
  input  logic              done_evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] data_o,
  output logic              start_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] data_q, status_w, ctrl_w;
  logic ie_q, pend_q, ovr_q, busy_w;
  logic data_wr, ctrl_wr, stat_rd;

  assign busy_w  = seq_busy_i || paper_out_i;
  assign data_wr = hit_i && wr_i && (off_i == REG_W'(OFF_DATA));
  assign ctrl_wr = hit_i && wr_i && (off_i == REG_W'(OFF_CTRL));
  assign stat_rd = hit_i && rd_i && (off_i == REG_W'(OFF_STATUS));
  assign start_o = data_wr && !busy_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (start_o) data_q <= wdata_i;
      if (ctrl_wr) ie_q   <= wdata_i[CTRL_IE];
      // completion outranks acknowledge
      if (done_evt_i)                 pend_q <= 1'b1;
      else if (stat_rd || data_wr)    pend_q <= 1'b0;
      if (data_wr && busy_w)          ovr_q  <= 1'b1;
      else if (stat_rd)               ovr_q  <= 1'b0;
    end
  end

  always_comb begin
    status_w           = '0;
    status_w[ST_BUSY]  = busy_w;
    status_w[ST_PAPER] = paper_out_i;
    status_w[ST_PEND]  = pend_q;
    status_w[ST_OVR]   = ovr_q;
    ctrl_w             = '0;
    ctrl_w[CTRL_IE]    = ie_q;
  end

  always_comb begin
    rdata_o = '0;
    if (hit_i && rd_i) begin
      if      (off_i == REG_W'(OFF_STATUS)) rdata_o = status_w;
      else if (off_i == REG_W'(OFF_DATA))   rdata_o = data_q;
      else if (off_i == REG_W'(OFF_CTRL))   rdata_o = ctrl_w;
    end
  end

  assign data_o = data_q;
  assign irq_o  = pend_q && ie_q;

  // R6
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && busy_w) |=> ovr_q);
  // R8
  pending_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(done_evt_i));
  // R9
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_evt_i && ie_q && !ctrl_wr) |=> irq_o);
endmodule

// File: rtl/pxu_top.sv
module pxu_top #(
  parameter int ADDR_W  = 16,
  parameter int SEL_W   = 3,
  parameter int REG_W   = 2,
  parameter int DATA_W  = 8,
  parameter int SLOT_ID = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] per_data_o,
  output logic              per_strobe_o,
  input  logic              per_done_i,
  input  logic              per_paper_out_i
);
  logic             hit, start, seq_busy, done_evt;
  logic [REG_W-1:0] off;

  pxu_decode #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .REG_W(REG_W), .SLOT_ID(SLOT_ID)
  ) i_decode (
    .addr_i(bus_addr_i), .hit_o(hit), .off_o(off)
  );

  pxu_regs #(.DATA_W(DATA_W), .REG_W(REG_W)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .off_i(off),
    .wr_i(bus_wr_i), .rd_i(bus_rd_i), .wdata_i(bus_wdata_i),
    .seq_busy_i(seq_busy), .paper_out_i(per_paper_out_i),
    .done_evt_i(done_evt), .rdata_o(bus_rdata_o), .data_o(per_data_o),
    .start_o(start), .irq_o(irq_o)
  );

  pxu_seq i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .paper_out_i(per_paper_out_i), .done_i(per_done_i),
    .strobe_o(per_strobe_o), .busy_o(seq_busy), .done_evt_o(done_evt)
  );

  // R1
  foreign_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i[ADDR_W-1 -: SEL_W] != SEL_W'(SLOT_ID)) |-> !start);
endmodule

// File: tb/test_pxu_top.sv
module test_pxu_top;
  localparam int SLOT = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pdata;
  logic       irq, strobe;
  logic       done = 1'b0, paper = 1'b0;

  int n_tests = 0, n_fail = 0, n_strobe = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  pxu_top i_pxu_top (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq),
    .per_data_o(pdata), .per_strobe_o(strobe), .per_done_i(done),
    .per_paper_out_i(paper)
  );

  function automatic logic [15:0] mk_addr(int slot, int off);
    return {slot[2:0], 11'b0, off[1:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(int slot, int off, logic [7:0] d);
    @(negedge clk);
    addr = mk_addr(slot, off); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // driver: accepted characters go on the scoreboard
  task automatic put_char(logic [7:0] d);
    exp_q.push_back(d);
    bus_wr(SLOT, 1, d);
  endtask

  task automatic bus_rd(int slot, int off, output logic [7:0] d);
    @(negedge clk);
    addr = mk_addr(slot, off); rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected bytes as strobes appear
  initial forever begin
    @(negedge clk);
    #1;
    if (strobe) begin
      n_strobe++;
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R4: got strobe with byte %0h expected no strobe", pdata);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (pdata !== e) begin
          n_fail++;
          $display("FAIL R4: got byte %0h expected %0h", pdata, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int s0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R10 reset state
    chk("R10 irq", irq, 0);
    chk("R10 strobe", strobe, 0);
    bus_rd(SLOT, 0, d); chk("R10 status", d, 8'h00);
    bus_rd(SLOT, 2, d); chk("R10 ctrl", d, 8'h00);

    // R4 R5 R9 polling mode
    put_char(8'h41);
    bus_rd(SLOT, 0, d); chk("R4 busy after write", d, 8'h01);
    bus_rd(SLOT, 1, d); chk("R2 data readback", d, 8'h41);
    pulse_done();
    chk("R9 polling no irq", irq, 0);
    bus_rd(SLOT, 0, d); chk("R5 R3 done clears busy, pending", d, 8'h04);
    bus_rd(SLOT, 0, d); chk("R8 status read clears pending", d, 8'h00);

    // R5 done while idle ignored
    pulse_done();
    bus_rd(SLOT, 0, d); chk("R5 stray done", d, 8'h00);

    // R1 foreign slot and nonzero reserved bits
    s0 = n_strobe;
    bus_wr(3, 1, 8'hEE);
    @(negedge clk); addr = mk_addr(SLOT, 1) | 16'h0100; wdata = 8'hEF; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    bus_wr(2, 2, 8'h01);
    idle(3);
    chk("R1 foreign write no strobe", n_strobe, s0);
    bus_rd(SLOT, 1, d); chk("R1 data unchanged", d, 8'h41);
    bus_rd(SLOT, 2, d); chk("R1 ctrl unchanged", d, 8'h00);
    bus_rd(6, 1, d);    chk("R1 foreign read zero", d, 8'h00);

    // R2 control and unused offset
    bus_wr(SLOT, 2, 8'hFF);
    bus_rd(SLOT, 2, d); chk("R2 ctrl readback", d, 8'h01);
    bus_rd(SLOT, 3, d); chk("R2 offset 3 zero", d, 8'h00);

    // R9 R8 interrupt mode
    put_char(8'h5A);
    pulse_done();
    chk("R9 irq raised", irq, 1);
    bus_rd(SLOT, 0, d); chk("R8 pending seen", d, 8'h04);
    chk("R8 irq cleared by status read", irq, 0);
    put_char(8'h5B);
    pulse_done();
    chk("R9 irq raised again", irq, 1);
    put_char(8'h5C);
    chk("R8 irq cleared by data write", irq, 0);
    pulse_done();
    bus_wr(SLOT, 2, 8'h00);
    chk("R9 enable off masks irq", irq, 0);
    bus_rd(SLOT, 0, d); chk("R8 pending kept with irq masked", d, 8'h04);

    // R6 overrun
    put_char(8'h11);
    bus_wr(SLOT, 1, 8'h22);
    bus_rd(SLOT, 0, d); chk("R6 overrun flagged", d, 8'h09);
    bus_rd(SLOT, 0, d); chk("R6 overrun cleared by read", d, 8'h01);
    bus_rd(SLOT, 1, d); chk("R6 data kept", d, 8'h11);
    pulse_done();
    bus_rd(SLOT, 0, d); chk("R6 after done", d, 8'h04);

    // R7 paper out while idle
    @(negedge clk); paper = 1'b1;
    bus_rd(SLOT, 0, d); chk("R7 R3 paper status", d, 8'h03);
    bus_wr(SLOT, 1, 8'h77);
    bus_rd(SLOT, 0, d); chk("R7 write while paper-out", d, 8'h0B);
    @(negedge clk); paper = 1'b0;
    bus_rd(SLOT, 0, d); chk("R7 paper released", d, 8'h00);

    // R7 paper out right after accept holds the strobe
    s0 = n_strobe;
    exp_q.push_back(8'h33);
    @(negedge clk); addr = mk_addr(SLOT, 1); wdata = 8'h33; wr = 1'b1;
    @(negedge clk); wr = 1'b0; paper = 1'b1;
    idle(5);
    chk("R7 strobe held", n_strobe, s0);
    bus_rd(SLOT, 0, d); chk("R7 held status", d, 8'h03);
    @(negedge clk); paper = 1'b0;
    idle(2);
    chk("R7 strobe after release", n_strobe, s0 + 1);
    pulse_done();
    bus_rd(SLOT, 0, d); chk("R7 completes", d, 8'h04);

    idle(2);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule